// File: doc/BRIEF.md
# Drowsy-Tag Set Lookup Sequencer

This block runs the tag lookup for one set of a set-associative cache in which both the tag and the data of a way may sit in a low-voltage retention state. In such a state the way keeps its contents but cannot be read.

Each lookup starts with a probe. The probe compares only the ways whose tags are awake. A match there answers in that same cycle. If every way is awake and none matches, the probe reports a miss with the victim way supplied from outside. Otherwise the block asks for every drowsy way of the set to be woken in the next cycle. One cycle after that, it compares all ways again and answers with either a hit or a miss.

In the answer cycle, the block sends each way it had woken back to retention, except the one that is still needed. That way is the hit way, or on a miss the victim, which must stay awake for the refill. The sleep request goes out alongside the answer and does not delay it. The block takes one request at a time and shows through a ready output that it is free.

States:
- `S_IDLE`: waiting; ready is high.
- `S_PROBE`: compare the awake ways only.
- `S_WAKE`: issue the wake command for the ways that were drowsy.
- `S_RECMP`: compare all ways, respond, and send the extra woken ways back to sleep.

Transitions:
- `S_IDLE` to `S_PROBE` when a request is accepted.
- `S_PROBE` to `S_IDLE` on an awake hit, or on a miss when every way was awake.
- `S_PROBE` to `S_WAKE` when no awake way matched and at least one way was drowsy.
- `S_WAKE` to `S_RECMP` always.
- `S_RECMP` to `S_IDLE` always.

Top module: `drowsy_lookup_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid`, `wake_cmd` and `sleep_cmd` are all 0.
- R2: A request is taken only while `req_ready` is 1, and `req_ready` is 1 only in the idle state. A request presented while the block is busy changes neither the result nor the operation of the lookup in progress.
- R3: When an awake way (`way_drowsy[w]` = 0) holds the request tag, the cycle right after acceptance shows `resp_valid` = 1, `resp_hit` = 1 and `resp_way` = w, with no wake or sleep command.
- R4: In the probe cycle, a way with `way_drowsy` = 1 takes no part in the compare. If only such a way matches, the probe cycle gives no response.
- R5: When all ways are awake and none matches, the probe cycle shows `resp_valid` = 1, `resp_hit` = 0 and `resp_way` = `repl_way`.
- R6: When the probe finds no awake match and some way is drowsy, the next cycle drives `wake_cmd` equal to the `way_drowsy` mask seen in the probe cycle (bit w is way w), with `resp_valid` = 0 and `req_ready` = 0.
- R7: The cycle after the wake cycle compares all ways. On a match it shows `resp_valid` = 1, `resp_hit` = 1 and `resp_way` = the matching way.
- R8: In the recompare response cycle, `sleep_cmd` equals the woken mask with the kept way's bit cleared. The kept way is the hit way, or the victim on a miss. Sleep is asserted only in a response cycle, and `req_ready` returns to 1 in the next cycle.
- R9: A miss after the recompare shows `resp_hit` = 0 and `resp_way` = `repl_way`.
- R10: When several enabled ways match, the lowest-numbered way is reported.
- R11: `set_idx` holds the accepted `req_idx`, and `resp_write` holds the accepted `req_write`, until the lookup ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request will be taken |
| req_idx | input | IDX_W | Set index of the request |
| req_tag | input | TAG_W | Tag to look up |
| req_write | input | 1 | 1 = write, 0 = read |
| set_idx | output | IDX_W | Held index driven to the tag and data arrays |
| way_drowsy | input | NUM_WAYS | Retention flag per way of the indexed set |
| way_tags | input | NUM_WAYS*TAG_W | Tags of the indexed set; way w in bits [w*TAG_W +: TAG_W] |
| repl_way | input | log2(NUM_WAYS) | Victim way chosen by the replacement logic |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | log2(NUM_WAYS) | Hit way, or victim way on a miss |
| resp_write | output | 1 | Operation to perform on a hit |
| wake_cmd | output | NUM_WAYS | Per-way wake request |
| sleep_cmd | output | NUM_WAYS | Per-way return-to-retention request |

## Verification
The hardest case to reach is a match that only a drowsy way holds. It leads to the wake path, and that path's result depends on the retention flags dropping between the wake cycle and the recompare. The bench acts as the array: it clears the flags in the wake cycle. It sweeps every one of the sixteen drowsy masks against every match position, including no match, with the victim way rotating. This covers each sleep mask, including the masks where the victim was already awake. During the wake cycle it also presents a competing request with a different tag and operation, and checks that the response still reflects the first request.

// File: rtl/dls_pkg.sv
package dls_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROBE = 2'd1,
        S_WAKE  = 2'd2,
        S_RECMP = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dls_tag_match.sv
module dls_tag_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    parameter int WAY_W    = 2
) (
    input  logic [TAG_W-1:0]          key,
    input  logic [NUM_WAYS*TAG_W-1:0] tags,
    input  logic [NUM_WAYS-1:0]       enable,
    output logic                      any,
    output logic [WAY_W-1:0]          way
);
    logic [NUM_WAYS-1:0] eq;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign eq[w] = enable[w] && (tags[w*TAG_W +: TAG_W] == key);
    end

    // lowest way wins: scan downward so the last assignment is the lowest
    always_comb begin
        any = 1'b0;
        way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                any = 1'b1;
                way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/dls_way_cmd.sv
module dls_way_cmd #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic                issue_wake,
    input  logic                issue_sleep,
    input  logic [NUM_WAYS-1:0] woken,
    input  logic [WAY_W-1:0]    keep_way,
    output logic [NUM_WAYS-1:0] wake_cmd,
    output logic [NUM_WAYS-1:0] sleep_cmd
);
    assign wake_cmd = issue_wake ? woken : '0;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_sleep
        assign sleep_cmd[w] = issue_sleep && woken[w] && (keep_way != WAY_W'(w));
    end
endmodule

// File: rtl/drowsy_lookup_seq.sv
module drowsy_lookup_seq
    import dls_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int IDX_W    = 4,
    parameter int TAG_W    = 8,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [IDX_W-1:0]          req_idx,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic                      req_write,
    output logic [IDX_W-1:0]          set_idx,
    input  logic [NUM_WAYS-1:0]       way_drowsy,
    input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
    input  logic [WAY_W-1:0]          repl_way,
    output logic                      resp_valid,
    output logic                      resp_hit,
    output logic [WAY_W-1:0]          resp_way,
    output logic                      resp_write,
    output logic [NUM_WAYS-1:0]       wake_cmd,
    output logic [NUM_WAYS-1:0]       sleep_cmd
);
    seq_state_e          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [TAG_W-1:0]    tag_q;
    logic                wr_q;
    logic [NUM_WAYS-1:0] woken_q;
    logic [NUM_WAYS-1:0] match_en;
    logic                m_any;
    logic [WAY_W-1:0]    m_way;
    logic                all_awake;
    logic                issue_wake, issue_sleep;

    // probe compares awake ways only; recompare sees every way
    assign match_en  = (state_q == S_RECMP) ? {NUM_WAYS{1'b1}} : ~way_drowsy;
    assign all_awake = (way_drowsy == '0);

    dls_tag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .WAY_W    (WAY_W)
    ) u_match (
        .key    (tag_q),
        .tags   (way_tags),
        .enable (match_en),
        .any    (m_any),
        .way    (m_way)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_PROBE;
            S_PROBE: state_d = (m_any || all_awake) ? S_IDLE : S_WAKE;
            S_WAKE:  state_d = S_RECMP;
            S_RECMP: state_d = S_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            tag_q   <= '0;
            wr_q    <= 1'b0;
            woken_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                idx_q <= req_idx;
                tag_q <= req_tag;
                wr_q  <= req_write;
            end
            if (state_q == S_PROBE) woken_q <= way_drowsy;
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        resp_valid  = 1'b0;
        resp_hit    = 1'b0;
        resp_way    = m_any ? m_way : repl_way;
        issue_wake  = 1'b0;
        issue_sleep = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_PROBE: begin
                resp_valid = m_any || all_awake;
                resp_hit   = m_any;
            end
            S_WAKE:  issue_wake = 1'b1;
            S_RECMP: begin
                resp_valid  = 1'b1;
                resp_hit    = m_any;
                issue_sleep = 1'b1;
            end
        endcase
    end

    assign set_idx    = idx_q;
    assign resp_write = wr_q;

    dls_way_cmd #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_cmd (
        .issue_wake  (issue_wake),
        .issue_sleep (issue_sleep),
        .woken       (woken_q),
        .keep_way    (resp_way),
        .wake_cmd    (wake_cmd),
        .sleep_cmd   (sleep_cmd)
    );

    // R4: a probe-cycle hit never names a way flagged drowsy
    p_probe_awake_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && resp_valid && resp_hit) |-> !way_drowsy[resp_way]);

    // R6: no response while waking
    p_wake_no_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_cmd != '0) |-> !resp_valid);

    // R7: a wake cycle is always followed by a response
    p_wake_then_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_cmd != '0) |=> resp_valid);

    // R8: sleep only together with a response
    p_sleep_in_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd != '0) |-> resp_valid);

    // R8: only ways woken in the previous cycle are put back to sleep
    p_sleep_from_woken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd != '0) |-> ((sleep_cmd & ~$past(wake_cmd)) == '0));

    // R2: ready comes back right after any response
    p_ready_after_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    // R11: the array index stays put while a lookup is running
    p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(set_idx));
endmodule

// File: tb/drowsy_lookup_seq_tb.sv
module drowsy_lookup_seq_tb;
    localparam int NW    = 4;
    localparam int IDX_W = 4;
    localparam int TAG_W = 8;
    localparam int WAY_W = 2;
    localparam logic [TAG_W-1:0] KEY = 8'hA5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic [IDX_W-1:0]       req_idx = '0;
    logic [TAG_W-1:0]       req_tag = '0;
    logic                   req_write = 1'b0;
    logic [IDX_W-1:0]       set_idx;
    logic [NW-1:0]          way_drowsy = '0;
    logic [NW*TAG_W-1:0]    way_tags = '0;
    logic [WAY_W-1:0]       repl_way = '0;
    logic                   resp_valid, resp_hit, resp_write;
    logic [WAY_W-1:0]       resp_way;
    logic [NW-1:0]          wake_cmd, sleep_cmd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    drowsy_lookup_seq #(.NUM_WAYS(NW), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_tag(req_tag), .req_write(req_write),
        .set_idx(set_idx), .way_drowsy(way_drowsy), .way_tags(way_tags),
        .repl_way(repl_way), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_write(resp_write),
        .wake_cmd(wake_cmd), .sleep_cmd(sleep_cmd)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // tgt = NW means no way holds the key; any other value puts the key in way tgt
    task automatic build_tags(input int tgt, input bit all_key);
        for (int w = 0; w < NW; w++)
            way_tags[w*TAG_W +: TAG_W] = (all_key || w == tgt) ? KEY : TAG_W'(8'h40 + w);
    endtask

    task automatic run_case(input int dmask, input int tgt, input int repl,
                            input bit wr, input int idx, input bit all_key);
        bit awake_hit;
        int exp_way;
        int keep;
        @(negedge clk);
        check("R2", "ready before request", int'(req_ready), 1);
        req_valid  = 1'b1;
        req_idx    = IDX_W'(idx);
        req_tag    = KEY;
        req_write  = wr;
        way_drowsy = NW'(dmask);
        repl_way   = WAY_W'(repl);
        build_tags(tgt, all_key);
        // lowest awake match when all ways hold the key
        awake_hit = 1'b0;
        exp_way   = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            if ((all_key || w == tgt) && !dmask[w]) begin
                awake_hit = 1'b1;
                exp_way   = w;
            end
        end
        @(negedge clk);  // probe cycle
        req_valid = 1'b0;
        check("R11", "set_idx in probe", int'(set_idx), idx);
        check("R2", "ready low in probe", int'(req_ready), 0);
        if (awake_hit) begin
            check("R3", "probe resp_valid", int'(resp_valid), 1);
            check("R3", "probe resp_hit", int'(resp_hit), 1);
            check(all_key ? "R10" : "R3", "probe resp_way", int'(resp_way), exp_way);
            check("R3", "probe no wake", int'(wake_cmd), 0);
            check("R11", "probe resp_write", int'(resp_write), int'(wr));
        end else if (dmask == 0) begin
            check("R5", "probe resp_valid", int'(resp_valid), 1);
            check("R5", "probe resp_hit", int'(resp_hit), 0);
            check("R5", "probe victim", int'(resp_way), repl);
            check("R5", "probe no wake", int'(wake_cmd), 0);
        end else begin
            check("R4", "probe no response", int'(resp_valid), 0);
            @(negedge clk);  // wake cycle
            check("R6", "wake mask", int'(wake_cmd), dmask);
            check("R6", "no resp in wake", int'(resp_valid), 0);
            check("R6", "ready low in wake", int'(req_ready), 0);
            // competing request while busy, array flags drop as ways wake
            req_valid  = 1'b1;
            req_tag    = ~KEY;
            req_write  = ~wr;
            req_idx    = ~IDX_W'(idx);
            way_drowsy = '0;
            @(negedge clk);  // recompare cycle
            req_valid = 1'b0;
            exp_way = repl;
            for (int w = NW - 1; w >= 0; w--)
                if (all_key || w == tgt) exp_way = w;
            keep = exp_way;
            check("R7", "recmp resp_valid", int'(resp_valid), 1);
            if (all_key || tgt < NW) begin
                check("R7", "recmp resp_hit", int'(resp_hit), 1);
                check(all_key ? "R10" : "R7", "recmp hit way", int'(resp_way), exp_way);
            end else begin
                check("R9", "recmp resp_hit", int'(resp_hit), 0);
                check("R9", "recmp victim", int'(resp_way), repl);
            end
            check("R8", "sleep mask", int'(sleep_cmd), dmask & ~(1 << keep));
            check("R2", "busy request ignored, write", int'(resp_write), int'(wr));
            check("R11", "set_idx in recmp", int'(set_idx), idx);
        end
        @(negedge clk);  // back to idle
        check("R8", "ready after response", int'(req_ready), 1);
        check("R8", "no resp in idle", int'(resp_valid), 0);
        check("R8", "no sleep in idle", int'(sleep_cmd), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset ready", int'(req_ready), 1);
        check("R1", "reset resp_valid", int'(resp_valid), 0);
        check("R1", "reset wake", int'(wake_cmd), 0);
        check("R1", "reset sleep", int'(sleep_cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", int'(req_ready), 1);
        // full sweep of retention masks against match positions
        for (int m = 0; m < (1 << NW); m++)
            for (int t = 0; t <= NW; t++)
                run_case(m, t, (m + t) % NW, 1'((m + t) & 1), (m * 3 + t) % (1 << IDX_W), 1'b0);
        // R10: several ways hold the key
        run_case(0,  NW, 2, 1'b0, 5, 1'b1);
        run_case(1,  NW, 3, 1'b1, 6, 1'b1);
        run_case(15, NW, 3, 1'b0, 7, 1'b1);
        run_case(6,  NW, 1, 1'b1, 9, 1'b1);
        done = 1'b1;
        report();
    end
endmodule